// File: doc/BRIEF.md
# I2C Register Target

This block is a target (slave) on a two-wire I2C bus that exposes a small bank of byte registers through an 8-bit register pointer. It samples the bus clock and data lines with the system clock and finds start and stop conditions. It compares each address byte with its own 7-bit device address and answers only when the address matches. The device address joins a 4-bit prefix, fixed by parameter, with three strap inputs, so up to eight copies can sit on one bus.

A write transfer first loads the pointer and then stores the following bytes at consecutive register indices. A read transfer returns the byte at the pointer and moves on to the next byte for as long as the controller acknowledges. The pointer survives stop and repeated-start conditions. A controller can therefore set it in a write phase, issue a repeated start, and read from that position. The data output is an open-drain enable: when `sda_oe` is 1, the SDA line is held low.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset and whenever the bus is idle, `sda_oe` is 0.
- R2: A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high. After a stop the block answers nothing until the next start.
- R3: The device address is {ADDR_PREFIX, addr_sel}, held in address-byte bits 7..1. The block holds SDA low through the ninth clock of an address byte only when these bits match.
- R4: After an address that does not match, the block drives nothing and changes no register until the next start.
- R5: Bit 0 of the address byte selects the direction: 0 means write and 1 means read.
- R6: In a write, the first byte after the address loads the 8-bit pointer and is acknowledged.
- R7: Every later write byte is stored at register index (pointer mod DEPTH) and acknowledged, and the pointer then increments with 8-bit wrap.
- R8: In a read, the byte at index (pointer mod DEPTH) is shifted out MSB first over eight clocks, and the pointer then increments. When the controller acknowledges, the block sends the next byte.
- R9: When the controller does not acknowledge a read byte, the block releases SDA and waits for a stop or start.
- R10: The pointer is kept across stop and repeated start. A read with no preceding pointer byte starts at the kept pointer.
- R11: `sda_oe` changes only while SCL is low. The acknowledge is released after the falling edge that ends the ninth clock.
- R12: Every register resets to 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| addr_sel | input | 3 | Strap bits forming the low part of the device address |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The bench sweeps all 128 address values and all eight strap settings. A decoder that compared the wrong bits, or that took the direction bit as part of the address, would acknowledge strangers or miss its own address. Pointer wrap at the top of the bank is exercised, as is a pointer value above DEPTH. A design that mishandled either would write outside the bank or return the wrong byte. The bench checks that the pointer is kept across a stop and across a repeated start; a design that cleared it on start would read from index zero. Other cases covered are a controller NACK followed by stray clocks, bytes sent to a foreign address, and bytes clocked in after a stop with no new start. Any of these would expose a design that drives SDA or writes a register when it should stay silent.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ACK,
      ST_RX,
      ST_TX,
      ST_TXACK,
      ST_IGNORE
   } tgt_state_e;

   localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= d;
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
   parameter int unsigned DEPTH      = 16,
   parameter int unsigned IDX_W      = 4,
   parameter bit          RESET_REGS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [7:0]       wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [7:0]       rd_data
);
   logic [7:0] cells [DEPTH];

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_cell
         logic [7:0] val;
         if (RESET_REGS) begin : g_rst
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                                 val <= '0;
               else if (wr_en && wr_idx == IDX_W'(g))      val <= wr_data;
            end
         end else begin : g_norst
            always_ff @(posedge clk) begin
               if (wr_en && wr_idx == IDX_W'(g)) val <= wr_data;
            end
         end
         assign cells[g] = val;
      end
   endgenerate

   assign rd_data = cells[rd_idx];
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
   import i2c_tgt_pkg::*;
#(
   parameter logic [3:0]  ADDR_PREFIX = 4'b1010,
   parameter int unsigned IDX_W       = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_s,
   input  logic             sda_s,
   input  logic [2:0]       addr_sel,
   input  logic [7:0]       rd_data,
   output logic [IDX_W-1:0] rd_idx,
   output logic             wr_en,
   output logic [IDX_W-1:0] wr_idx,
   output logic [7:0]       wr_data,
   output logic             sda_oe,
   output tgt_state_e       st
);
   logic       scl_q, sda_q;
   logic [3:0] cnt;
   logic [7:0] shreg;
   logic [7:0] ptr;
   logic       ptr_set, is_read, mst_ack;

   wire scl_rise = scl_s & ~scl_q;
   wire scl_fall = ~scl_s & scl_q;
   wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
   wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;
   wire [6:0] own_addr = {ADDR_PREFIX, addr_sel};

   assign rd_idx = ptr[IDX_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q   <= 1'b1;
         sda_q   <= 1'b1;
         st      <= ST_IDLE;
         cnt     <= '0;
         shreg   <= '0;
         ptr     <= '0;
         ptr_set <= 1'b0;
         is_read <= 1'b0;
         mst_ack <= 1'b0;
         sda_oe  <= 1'b0;
         wr_en   <= 1'b0;
         wr_idx  <= '0;
         wr_data <= '0;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
         wr_en <= 1'b0;
         if (start_c) begin
            st      <= ST_ADDR;
            cnt     <= '0;
            sda_oe  <= 1'b0;
            ptr_set <= 1'b0;
         end else if (stop_c) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            unique case (st)
               ST_ADDR, ST_RX: begin
                  if (scl_rise) begin
                     shreg <= {shreg[6:0], sda_s};
                     cnt   <= cnt + 4'd1;
                  end else if (scl_fall && cnt == 4'd8) begin
                     if (st == ST_ADDR) begin
                        if (shreg[7:1] == own_addr) begin
                           is_read <= shreg[0];
                           sda_oe  <= 1'b1;
                           st      <= ST_ACK;
                        end else begin
                           st <= ST_IGNORE;
                        end
                     end else begin
                        sda_oe <= 1'b1;
                        st     <= ST_ACK;
                        if (!ptr_set) begin
                           ptr     <= shreg;
                           ptr_set <= 1'b1;
                        end else begin
                           wr_en   <= 1'b1;
                           wr_idx  <= ptr[IDX_W-1:0];
                           wr_data <= shreg;
                           ptr     <= ptr + 8'd1;
                        end
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     cnt <= '0;
                     if (is_read) begin
                        shreg  <= rd_data;
                        sda_oe <= ~rd_data[7];
                        st     <= ST_TX;
                     end else begin
                        sda_oe <= 1'b0;
                        st     <= ST_RX;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_rise) begin
                     cnt <= cnt + 4'd1;
                  end else if (scl_fall) begin
                     if (cnt == 4'd8) begin
                        sda_oe <= 1'b0;
                        ptr    <= ptr + 8'd1;
                        st     <= ST_TXACK;
                     end else begin
                        shreg  <= {shreg[6:0], 1'b0};
                        sda_oe <= ~shreg[6];
                     end
                  end
               end
               ST_TXACK: begin
                  if (scl_rise) begin
                     mst_ack <= ~sda_s;
                  end else if (scl_fall) begin
                     if (mst_ack) begin
                        cnt    <= '0;
                        shreg  <= rd_data;
                        sda_oe <= ~rd_data[7];
                        st     <= ST_TX;
                     end else begin
                        st <= ST_IGNORE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
   import i2c_tgt_pkg::*;
#(
   parameter logic [3:0]  ADDR_PREFIX = 4'b1010,
   parameter int unsigned DEPTH       = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          RESET_REGS  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic [2:0] addr_sel,
   output logic       sda_oe
);
   localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 2 || DEPTH > 256 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two between 2 and 256");
      end
      if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 2 to 4");
      end
   endgenerate

   logic             scl_s, sda_s;
   logic             wr_en;
   logic [IDX_W-1:0] wr_idx, rd_idx;
   logic [7:0]       wr_data, rd_data;
   tgt_state_e       st;

   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

   i2c_tgt_ctrl #(.ADDR_PREFIX(ADDR_PREFIX), .IDX_W(IDX_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .addr_sel(addr_sel), .rd_data(rd_data), .rd_idx(rd_idx),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .sda_oe(sda_oe), .st(st));

   i2c_reg_bank #(.DEPTH(DEPTH), .IDX_W(IDX_W), .RESET_REGS(RESET_REGS)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data));
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk
   import i2c_tgt_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       scl_i,
   input logic       sda_oe,
   input logic       scl_s,
   input logic       sda_s,
   input tgt_state_e st
);
   assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> !sda_oe);

   assert_stop_to_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_s && $past(scl_s) && sda_s && !$past(sda_s)) |=> (st == ST_IDLE));

   assert_drive_high_only_ack_or_tx_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe && scl_s) |-> (st == ST_ACK || st == ST_TX));

   assert_foreign_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IGNORE) |-> !sda_oe);

   assert_nack_slot_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_TXACK) |-> !sda_oe);

   assert_change_while_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_i);
endmodule

bind i2c_reg_target i2c_reg_target_chk u_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
   .scl_s(scl_s), .sda_s(sda_s), .st(st));

// File: tb/i2c_reg_target_tb.sv
`timescale 1ns/1ps
module i2c_reg_target_tb;
   localparam logic [3:0] PFX  = 4'b1010;
   localparam int         NREG = 16;
   localparam int         Q    = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_scl = 1'b1;
   logic       m_sda = 1'b1;
   logic [2:0] straps = 3'b101;
   logic       sda_oe;
   wire        sda_bus = m_sda & ~sda_oe;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   i2c_reg_target #(.ADDR_PREFIX(PFX), .DEPTH(NREG)) u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
      .addr_sel(straps), .sda_oe(sda_oe));

   function automatic logic [7:0] pat(int i);
      return 8'((i * 37 + 11) & 255);
   endfunction

   function automatic logic [7:0] own(logic rw);
      return {PFX, straps, rw};
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wq(int n);
      repeat (n * Q) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; wq(1);
      m_scl = 1'b1; wq(1);
      m_sda = 1'b0; wq(1);
      m_scl = 1'b0; wq(1);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; wq(1);
      m_scl = 1'b1; wq(1);
      m_sda = 1'b1; wq(1);
   endtask

   task automatic send_bit(logic b);
      m_sda = b; wq(1);
      m_scl = 1'b1; wq(2);
      m_scl = 1'b0; wq(1);
   endtask

   task automatic recv_bit(output logic b);
      m_sda = 1'b1; wq(1);
      m_scl = 1'b1; wq(1);
      b = sda_bus; wq(1);
      m_scl = 1'b0; wq(1);
   endtask

   task automatic wr_byte(logic [7:0] v, output logic ack);
      logic a;
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
      recv_bit(a);
      ack = ~a;
   endtask

   task automatic rd_byte(logic give_ack, output logic [7:0] v);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         recv_bit(b);
         v[i] = b;
      end
      send_bit(~give_ack);
   endtask

   task automatic set_ptr(logic [7:0] p);
      logic ack;
      bus_start();
      wr_byte(own(1'b0), ack);
      wr_byte(p, ack);
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic       ack;
      logic [7:0] v;
      repeat (5) @(negedge clk);
      check("R1 reset release", sda_oe, 0);
      rst_n = 1'b1;
      wq(2);
      check("R1 idle release", sda_oe, 0);

      // R12: all registers read as zero after reset
      set_ptr(8'h00);
      bus_start();
      wr_byte(own(1'b1), ack);
      check("R5 read address ack", ack, 1);
      for (int i = 0; i < NREG; i++) begin
         rd_byte(i != NREG - 1, v);
         check("R12 reset value", v, 0);
      end
      bus_stop();

      // R3: sweep every 7-bit address
      for (int a = 0; a < 128; a++) begin
         bus_start();
         wr_byte({7'(a), 1'b0}, ack);
         bus_stop();
         check("R3 address sweep", ack, (7'(a) == {PFX, straps}) ? 1 : 0);
      end

      // R3: every strap setting
      for (int s = 0; s < 8; s++) begin
         straps = 3'(s);
         bus_start();
         wr_byte({PFX, 3'(s), 1'b0}, ack);
         bus_stop();
         check("R3 strap match", ack, 1);
         bus_start();
         wr_byte({PFX, 3'(s) ^ 3'b010, 1'b0}, ack);
         bus_stop();
         check("R3 strap mismatch", ack, 0);
      end
      straps = 3'b101;

      // R6/R7/R11: load pointer, burst write
      bus_start();
      wr_byte(own(1'b0), ack);
      wr_byte(8'h00, ack);
      check("R6 pointer ack", ack, 1);
      check("R11 release after ack", sda_bus, 1);
      for (int i = 0; i < NREG; i++) begin
         wr_byte(pat(i), ack);
         check("R7 data ack", ack, 1);
      end
      bus_stop();

      // R8/R10: repeated start readback, R9 NACK release
      set_ptr(8'h00);
      bus_start();
      wr_byte(own(1'b1), ack);
      for (int i = 0; i < NREG; i++) begin
         rd_byte(i != NREG - 1, v);
         check("R8 burst read", v, pat(i));
      end
      recv_bit(ack);
      check("R9 released after nack", ack, 1);
      recv_bit(ack);
      check("R9 still released", ack, 1);
      bus_stop();

      // R4: foreign address with data
      bus_start();
      wr_byte(own(1'b0) ^ 8'h02, ack);
      check("R4 foreign no ack", ack, 0);
      wr_byte(8'h03, ack);
      check("R4 pointer byte ignored", ack, 0);
      wr_byte(8'hEE, ack);
      check("R4 data byte ignored", ack, 0);
      bus_stop();
      set_ptr(8'h03);
      bus_start();
      wr_byte(own(1'b1), ack);
      rd_byte(1'b0, v);
      bus_stop();
      check("R4 register untouched", v, pat(3));

      // R2: bytes after a stop without a new start are not answered
      bus_start();
      wr_byte(own(1'b0), ack);
      bus_stop();
      wr_byte(own(1'b0), ack);
      check("R2 no ack without start", ack, 0);
      bus_stop();

      // R7: pointer wrap at top of bank
      set_ptr(8'(NREG - 1));
      wr_byte(8'hA1, ack);
      wr_byte(8'hB2, ack);
      bus_stop();
      set_ptr(8'(NREG - 1));
      bus_start();
      wr_byte(own(1'b1), ack);
      rd_byte(1'b1, v);
      check("R7 last register", v, 8'hA1);
      rd_byte(1'b0, v);
      check("R7 wrapped to index 0", v, 8'hB2);
      bus_stop();

      // R7: pointer above DEPTH maps modulo DEPTH
      set_ptr(8'(NREG + 5));
      wr_byte(8'h5A, ack);
      bus_stop();
      set_ptr(8'h05);
      bus_start();
      wr_byte(own(1'b1), ack);
      rd_byte(1'b0, v);
      bus_stop();
      check("R7 index modulo depth", v, 8'h5A);

      // R10: pointer kept across stop; R8 increments between reads
      set_ptr(8'h06);
      bus_stop();
      bus_start();
      wr_byte(own(1'b1), ack);
      rd_byte(1'b0, v);
      bus_stop();
      check("R10 pointer kept across stop", v, pat(6));
      bus_start();
      wr_byte(own(1'b1), ack);
      rd_byte(1'b0, v);
      bus_stop();
      check("R8 pointer advanced", v, pat(7));

      wq(2);
      check("R1 idle at end", sda_oe, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule